// File: doc/BRIEF.md
# Vertical Blank Interrupt and Status Controller

This block follows the video beam position and produces the events a CPU needs at the end of each visible frame. When the beam enters the first vertical-blank line it raises a status flag and latches the forced-blank setting. If interrupts are enabled, it schedules a non-maskable interrupt that fires a fixed number of horizontal cycles into that line. A few lines later it can start the automatic controller read. When the frame wraps back to line 0, the status flag drops again.

The beam generator supplies a line-advance strobe, the new line number and the running horizontal cycle count. The CPU side receives a level interrupt request that stays high until the CPU acknowledges it. The CPU side also receives the scheduled trigger position. A CPU parked in a wait-for-interrupt state gets a wake pulse, followed by a stall window that models the cost of waking up.

Top module: `vbn_ctrl`

## Requirements
- R1: On a line advance to the first blank line, `status_o` becomes 0x80 with the chip revision `rev_i` placed in bits [3:0] (bits 6:4 zero) after the next clock edge.
- R2: On a line advance to line 0, `status_o` becomes the chip revision alone with bit 7 clear.
- R3: The first blank line is 225 when `tall_i` is 0 and 240 when `tall_i` is 1. An advance to the other value has no effect on status, NMI scheduling or the forced-blank latch.
- R4: When `ctrl_i[7]` is set at the start of vertical blank, an NMI becomes pending and `nmi_pos_o` reads 12. While nothing is pending, `nmi_pos_o` reads 0xFFFF.
- R5: A pending NMI fires on the clock edge where `hpos_i` is 12 or more. `nmi_req_o` goes high at that edge, and the pending state clears, so `nmi_pos_o` returns to 0xFFFF.
- R6: `nmi_req_o` stays high until a cycle with `nmi_ack_i` high and clears on that edge. A new firing in the same cycle wins over the acknowledge.
- R7: With `ctrl_i[7]` clear at the start of vertical blank, no NMI is scheduled and `nmi_req_o` stays low.
- R8: With `ctrl_i[0]` set, an advance to line screen-height+3 (227 short, 242 tall) gives a `joy_start_o` pulse exactly one cycle long after the edge. With `ctrl_i[0]` clear, no pulse appears.
- R9: `forced_blank_o` takes `disp_blank_i` at the start of vertical blank and holds it at every other time.
- R10: While `waiting_i` is high, an NMI firing or a high `irq_i` produces a one-cycle `wake_o` pulse and raises `wake_stall_o` for 14 cycles (two 6-cycle CPU cycles plus half of a 4-cycle dot). No new wake starts during the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_adv_i | input | 1 | Strobe: a new line begins, `line_i` holds its number |
| line_i | input | 9 | Current line number |
| hpos_i | input | 11 | Horizontal cycle count within the line |
| ctrl_i | input | 8 | Control: bit 7 NMI enable, bit 0 auto controller read enable |
| tall_i | input | 1 | Screen height select: 0 = 224 lines, 1 = 239 lines |
| rev_i | input | 4 | Chip revision for the status byte |
| disp_blank_i | input | 1 | Forced-blank bit of the display control register |
| nmi_ack_i | input | 1 | CPU acknowledge of the NMI request |
| irq_i | input | 1 | Maskable interrupt line, used only for waking |
| waiting_i | input | 1 | CPU is waiting for an interrupt |
| status_o | output | 8 | Readable blank status byte |
| nmi_req_o | output | 1 | Level NMI request |
| nmi_pos_o | output | 16 | Scheduled trigger cycle, 0xFFFF when idle |
| joy_start_o | output | 1 | One-cycle auto controller read start |
| forced_blank_o | output | 1 | Forced-blank flag latched at blank start |
| wake_o | output | 1 | One-cycle wake pulse for a waiting CPU |
| wake_stall_o | output | 1 | High during the wake cost window |

## Verification
A pending flag stuck at the wrong value shows at `nmi_pos_o` one edge after the blank-line strobe, well before the request itself would be late. A trigger comparison that is off by one shows up as `nmi_req_o` rising one cycle early or late on the ramp of `hpos_i`. A wrong line decode shows at the status byte, the forced-blank latch or the controller-read pulse on the very edge after the strobe. A wrong stall counter shows at `wake_stall_o` at the end of the 14-cycle window.

// File: rtl/vbn_pkg.sv
package vbn_pkg;

   localparam int STATUS_W    = 8;
   localparam int BLANK_BIT   = 7;
   localparam int NMI_EN_BIT  = 7;
   localparam int JOY_EN_BIT  = 0;

   typedef struct packed {
      logic blank_start;
      logic frame_wrap;
      logic joy_line;
   } vbn_line_ev_t;

   function automatic int wake_cost(input int cpu_cyc, input int dot_cyc);
      return 2 * cpu_cyc + dot_cyc / 2;
   endfunction

endpackage

// File: rtl/vbn_line_decode.sv
module vbn_line_decode
   import vbn_pkg::*;
#(
   parameter int LINE_W     = 9,
   parameter int H_SHORT    = 224,
   parameter int H_TALL     = 239,
   parameter int JOY_OFFSET = 3
) (
   input  logic              line_adv_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic              tall_i,
   output vbn_line_ev_t      ev_o
);

   localparam logic [LINE_W-1:0] BLANK_SHORT = LINE_W'(H_SHORT + 1);
   localparam logic [LINE_W-1:0] BLANK_TALL  = LINE_W'(H_TALL + 1);
   localparam logic [LINE_W-1:0] JOY_SHORT   = LINE_W'(H_SHORT + JOY_OFFSET);
   localparam logic [LINE_W-1:0] JOY_TALL    = LINE_W'(H_TALL + JOY_OFFSET);

   generate
      if (H_TALL + JOY_OFFSET >= (1 << LINE_W)) begin : g_bad_line_w
         $error("vbn_line_decode: LINE_W too narrow for the line count");
      end
      if (H_SHORT >= H_TALL) begin : g_bad_height
         $error("vbn_line_decode: short height must be below tall height");
      end
   endgenerate

   logic [LINE_W-1:0] blank_line;
   logic [LINE_W-1:0] joy_line;

   always_comb begin
      blank_line = tall_i ? BLANK_TALL : BLANK_SHORT;
      joy_line   = tall_i ? JOY_TALL   : JOY_SHORT;
   end

   always_comb begin
      ev_o.blank_start = line_adv_i && (line_i == blank_line);
      ev_o.frame_wrap  = line_adv_i && (line_i == '0);
      ev_o.joy_line    = line_adv_i && (line_i == joy_line);
   end

endmodule

// File: rtl/vbn_status.sv
module vbn_status
   import vbn_pkg::*;
#(
   parameter int REV_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  vbn_line_ev_t        ev_i,
   input  logic [REV_W-1:0]    rev_i,
   input  logic                disp_blank_i,
   output logic [STATUS_W-1:0] status_o,
   output logic                forced_blank_o
);

   localparam int PAD_W = BLANK_BIT - REV_W;

   generate
      if (REV_W < 1 || REV_W > BLANK_BIT) begin : g_bad_rev
         $error("vbn_status: REV_W must be 1 to 7");
      end
   endgenerate

   logic [BLANK_BIT-1:0] low_bits;

   generate
      if (PAD_W > 0) begin : g_pad
         assign low_bits = {{PAD_W{1'b0}}, rev_i};
      end else begin : g_nopad
         assign low_bits = rev_i;
      end
   endgenerate

   logic [STATUS_W-1:0] status_q;
   logic                fb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
      end else if (ev_i.blank_start) begin
         status_q <= {1'b1, low_bits};
      end else if (ev_i.frame_wrap) begin
         status_q <= {1'b0, low_bits};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fb_q <= 1'b0;
      end else if (ev_i.blank_start) begin
         fb_q <= disp_blank_i;
      end
   end

   assign status_o       = status_q;
   assign forced_blank_o = fb_q;

   p_blank_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i.blank_start |=> status_q[BLANK_BIT])
      else $error("R1 blank flag not set");

   p_wrap_clears_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i.frame_wrap && !ev_i.blank_start) |=> !status_q[BLANK_BIT])
      else $error("R2 blank flag not cleared");

   p_fb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_i.blank_start |=> $stable(fb_q))
      else $error("R9 forced blank changed outside blank start");

endmodule

// File: rtl/vbn_nmi_sched.sv
module vbn_nmi_sched #(
   parameter int HPOS_W     = 11,
   parameter int POS_W      = 16,
   parameter int NMI_OFFSET = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sched_i,
   input  logic [HPOS_W-1:0] hpos_i,
   input  logic              ack_i,
   output logic              req_o,
   output logic [POS_W-1:0]  pos_o,
   output logic              fire_o
);

   localparam logic [POS_W-1:0] IDLE_POS = '1;
   localparam logic [POS_W-1:0] TRIG_POS = POS_W'(NMI_OFFSET);

   generate
      if (HPOS_W > POS_W) begin : g_bad_pos_w
         $error("vbn_nmi_sched: HPOS_W must not exceed POS_W");
      end
      if (NMI_OFFSET >= (1 << HPOS_W)) begin : g_bad_offset
         $error("vbn_nmi_sched: NMI_OFFSET beyond the line");
      end
   endgenerate

   logic             pend_q;
   logic [POS_W-1:0] pos_q;
   logic             req_q;
   logic             fire;

   assign fire = pend_q && (POS_W'(hpos_i) >= pos_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pos_q  <= IDLE_POS;
      end else if (sched_i) begin
         pend_q <= 1'b1;
         pos_q  <= TRIG_POS;
      end else if (fire) begin
         pend_q <= 1'b0;
         pos_q  <= IDLE_POS;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (fire) begin
         req_q <= 1'b1;
      end else if (ack_i) begin
         req_q <= 1'b0;
      end
   end

   assign req_o  = req_q;
   assign pos_o  = pos_q;
   assign fire_o = fire;

   p_idle_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q |-> (pos_q == IDLE_POS))
      else $error("R4 idle trigger position wrong");

   p_fire_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !sched_i) |=> (!pend_q && req_q))
      else $error("R5 firing did not clear pending");

   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !ack_i) |=> req_q)
      else $error("R6 request dropped without ack");

   p_req_needs_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> $past(pend_q))
      else $error("R7 request without pending NMI");

endmodule

// File: rtl/vbn_wake.sv
module vbn_wake #(
   parameter int CPU_CYC = 6,
   parameter int DOT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting_i,
   input  logic fire_i,
   input  logic irq_i,
   output logic wake_o,
   output logic stall_o
);

   localparam int STALL = vbn_pkg::wake_cost(CPU_CYC, DOT_CYC);
   localparam int CNT_W = $clog2(STALL + 1);
   localparam logic [CNT_W-1:0] STALL_LD = CNT_W'(STALL);

   generate
      if (STALL < 1) begin : g_bad_stall
         $error("vbn_wake: stall length must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             wake_q;
   logic             start;

   assign start = waiting_i && (fire_i || irq_i) && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         wake_q <= 1'b0;
      end else begin
         wake_q <= start;
         if (start) begin
            cnt_q <= STALL_LD;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign wake_o  = wake_q;
   assign stall_o = (cnt_q != '0);

   p_wake_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |-> (cnt_q == STALL_LD))
      else $error("R10 stall not loaded on wake");

   p_wake_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |=> !wake_q)
      else $error("R10 wake pulse longer than one cycle");

endmodule

// File: rtl/vbn_ctrl.sv
module vbn_ctrl
   import vbn_pkg::*;
#(
   parameter int LINE_W     = 9,
   parameter int HPOS_W     = 11,
   parameter int POS_W      = 16,
   parameter int REV_W      = 4,
   parameter int H_SHORT    = 224,
   parameter int H_TALL     = 239,
   parameter int JOY_OFFSET = 3,
   parameter int NMI_OFFSET = 12,
   parameter int CPU_CYC    = 6,
   parameter int DOT_CYC    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_adv_i,
   input  logic [LINE_W-1:0]   line_i,
   input  logic [HPOS_W-1:0]   hpos_i,
   input  logic [7:0]          ctrl_i,
   input  logic                tall_i,
   input  logic [REV_W-1:0]    rev_i,
   input  logic                disp_blank_i,
   input  logic                nmi_ack_i,
   input  logic                irq_i,
   input  logic                waiting_i,
   output logic [STATUS_W-1:0] status_o,
   output logic                nmi_req_o,
   output logic [POS_W-1:0]    nmi_pos_o,
   output logic                joy_start_o,
   output logic                forced_blank_o,
   output logic                wake_o,
   output logic                wake_stall_o
);

   vbn_line_ev_t ev;
   logic         nmi_fire;
   logic         joy_q;
   logic         unused_ctrl;

   assign unused_ctrl = ^ctrl_i[6:1];

   vbn_line_decode #(
      .LINE_W     (LINE_W),
      .H_SHORT    (H_SHORT),
      .H_TALL     (H_TALL),
      .JOY_OFFSET (JOY_OFFSET)
   ) u_decode (
      .line_adv_i (line_adv_i),
      .line_i     (line_i),
      .tall_i     (tall_i),
      .ev_o       (ev)
   );

   vbn_status #(
      .REV_W (REV_W)
   ) u_status (
      .clk            (clk),
      .rst_n          (rst_n),
      .ev_i           (ev),
      .rev_i          (rev_i),
      .disp_blank_i   (disp_blank_i),
      .status_o       (status_o),
      .forced_blank_o (forced_blank_o)
   );

   vbn_nmi_sched #(
      .HPOS_W     (HPOS_W),
      .POS_W      (POS_W),
      .NMI_OFFSET (NMI_OFFSET)
   ) u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .sched_i (ev.blank_start && ctrl_i[NMI_EN_BIT]),
      .hpos_i  (hpos_i),
      .ack_i   (nmi_ack_i),
      .req_o   (nmi_req_o),
      .pos_o   (nmi_pos_o),
      .fire_o  (nmi_fire)
   );

   vbn_wake #(
      .CPU_CYC (CPU_CYC),
      .DOT_CYC (DOT_CYC)
   ) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .waiting_i (waiting_i),
      .fire_i    (nmi_fire),
      .irq_i     (irq_i),
      .wake_o    (wake_o),
      .stall_o   (wake_stall_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         joy_q <= 1'b0;
      end else begin
         joy_q <= ev.joy_line && ctrl_i[JOY_EN_BIT];
      end
   end

   assign joy_start_o = joy_q;

   p_joy_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(joy_q) |-> $past(ctrl_i[JOY_EN_BIT] && line_adv_i))
      else $error("R8 controller read pulse without enable");

   p_blank_wrap_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev.blank_start && ev.frame_wrap))
      else $error("R3 blank start and wrap decoded together");

endmodule

// File: tb/tb_vbn_ctrl.sv
module tb_vbn_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_adv = 1'b0;
   logic [8:0]  line = '0;
   logic [10:0] hpos = '0;
   logic [7:0]  ctrl = '0;
   logic        tall = 1'b0;
   logic [3:0]  rev = '0;
   logic        dblank = 1'b0;
   logic        ack = 1'b0;
   logic        irq = 1'b0;
   logic        waiting = 1'b0;

   logic [7:0]  status;
   logic        nmi_req;
   logic [15:0] nmi_pos;
   logic        joy;
   logic        fb;
   logic        wake;
   logic        stall;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   vbn_ctrl dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .line_adv_i     (line_adv),
      .line_i         (line),
      .hpos_i         (hpos),
      .ctrl_i         (ctrl),
      .tall_i         (tall),
      .rev_i          (rev),
      .disp_blank_i   (dblank),
      .nmi_ack_i      (ack),
      .irq_i          (irq),
      .waiting_i      (waiting),
      .status_o       (status),
      .nmi_req_o      (nmi_req),
      .nmi_pos_o      (nmi_pos),
      .joy_start_o    (joy),
      .forced_blank_o (fb),
      .wake_o         (wake),
      .wake_stall_o   (stall)
   );

   typedef struct {
      logic [7:0]  st;
      logic        req;
      logic [15:0] pos;
      logic        joy;
      logic        fb;
      logic        wake;
      logic        stall;
      string       tag;
   } exp_t;

   exp_t q[$];

   // reference model state, built from the requirements
   logic [7:0] m_status = '0;
   logic       m_pend   = 1'b0;
   logic       m_req    = 1'b0;
   logic       m_fb     = 1'b0;
   int         m_cnt    = 0;

   task automatic chk(string tag, string field, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, field, act, exp);
      end
   endtask

   // monitor: pops expected items after each clock edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "status R1_R2_R3", int'(status), int'(e.st));
            chk(e.tag, "nmi_req R5_R6_R7", int'(nmi_req), int'(e.req));
            chk(e.tag, "nmi_pos R4", int'(nmi_pos), int'(e.pos));
            chk(e.tag, "joy R8", int'(joy), int'(e.joy));
            chk(e.tag, "forced_blank R9", int'(fb), int'(e.fb));
            chk(e.tag, "wake R10", int'(wake), int'(e.wake));
            chk(e.tag, "stall R10", int'(stall), int'(e.stall));
         end
      end
   end

   // driver: predicts the state after the coming edge, pushes it, waits one cycle
   task automatic step(string tag);
      exp_t e;
      int   vb_line;
      int   joy_line;
      logic vb, wr, jl, fire, wk;
      vb_line  = tall ? 240 : 225;
      joy_line = tall ? 242 : 227;
      vb   = line_adv && (int'(line) == vb_line);
      wr   = line_adv && (line == 0);
      jl   = line_adv && (int'(line) == joy_line);
      fire = m_pend && (hpos >= 11'd12);
      wk   = waiting && (fire || irq) && (m_cnt == 0);
      if (vb)      m_status = {4'h8, rev};
      else if (wr) m_status = {4'h0, rev};
      if (vb) m_fb = dblank;
      if (fire)     m_req = 1'b1;
      else if (ack) m_req = 1'b0;
      if (vb && ctrl[7]) m_pend = 1'b1;
      else if (fire)     m_pend = 1'b0;
      if (wk)              m_cnt = 14;
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      e.st    = m_status;
      e.req   = m_req;
      e.pos   = m_pend ? 16'd12 : 16'hFFFF;
      e.joy   = jl && ctrl[0];
      e.fb    = m_fb;
      e.wake  = wk;
      e.stall = (m_cnt != 0);
      e.tag   = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic run_line(string tag, int n, int hmax);
      line     = 9'(n);
      hpos     = '0;
      line_adv = 1'b1;
      step(tag);
      line_adv = 1'b0;
      for (int h = 1; h <= hmax; h++) begin
         hpos = 11'(h);
         step(tag);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step("reset state");
      step("reset state");

      // short screen, NMI and controller read enabled, waiting CPU
      tall = 1'b0; ctrl = 8'h81; rev = 4'h5; dblank = 1'b1;
      run_line("R3 pre-blank line", 224, 4);
      waiting = 1'b1;
      run_line("R1 R4 R5 R9 R10 blank start", 225, 16);
      waiting = 1'b0;
      for (int i = 0; i < 16; i++) step("R6 R10 hold and stall");
      ack = 1'b1; step("R6 ack");
      ack = 1'b0; step("R6 after ack");
      run_line("R8 line 226", 226, 2);
      run_line("R8 joy line 227", 227, 3);
      run_line("R8 line 228", 228, 2);
      dblank = 1'b0;
      run_line("R2 frame wrap", 0, 3);
      run_line("R9 no relatch", 1, 2);

      // tall screen, everything disabled
      tall = 1'b1; ctrl = 8'h00; rev = 4'hA; dblank = 1'b0;
      run_line("R3 225 ignored when tall", 225, 14);
      run_line("R3 R7 blank start tall", 240, 16);
      run_line("R8 no joy when disabled", 242, 3);
      run_line("R2 wrap tall", 0, 2);

      // tall screen with NMI, ack arriving together with a new firing
      ctrl = 8'h81; rev = 4'h3; dblank = 1'b1;
      run_line("R4 tall schedule", 240, 11);
      ack = 1'b1; hpos = 11'd12;
      step("R6 fire beats ack");
      ack = 1'b0;
      step("R6 held");
      ack = 1'b1; step("R6 cleared");
      ack = 1'b0;
      run_line("R8 joy tall 242", 242, 2);

      // IRQ wake, then a second request during the stall is ignored
      waiting = 1'b1; irq = 1'b1;
      step("R10 irq wake");
      irq = 1'b0;
      for (int i = 0; i < 5; i++) step("R10 stall");
      irq = 1'b1;
      step("R10 irq during stall ignored");
      irq = 1'b0; waiting = 1'b0;
      for (int i = 0; i < 12; i++) step("R10 stall tail");
      run_line("R2 final wrap", 0, 2);
      step("idle");

      summary();
      $finish;
   end

endmodule